// File: doc/BRIEF.md
# Disk Controller Command/Result Phase Sequencer

This block runs the host side of a disk controller's byte-by-byte command protocol. A host polls two status bits: a ready flag (`rqm`) and a direction flag (`dio`). It writes an opcode byte and then the parameter bytes that opcode needs. The block decodes the opcode to learn how many parameters and result bytes belong to it. After the last parameter it runs a timed execution stand-in, raises an interrupt and offers the result bytes for the host to read one at a time.

Each accepted byte is followed by a programmable processing gap, `PROC_CYCLES` long, in which the ready flag is low. The data FIFO enable is passed on only while the execution stand-in runs, so the FIFO stays off for the whole command phase. An opcode outside the table ends the command at once and yields a single status byte. A new command is taken only after every result byte has been read.

Top module: `fdc_phase_seq`

## Requirements
- R1: After reset `rqm`=1, `dio`=0, `irq`=0 and `fifo_en`=0.
- R2: A host write is taken only in a cycle where `rqm`=1 and `dio`=0. A write in any other cycle changes neither the byte sequence nor the outputs.
- R3: After a write is taken, `rqm` is 0 for exactly `PROC_CYCLES` cycles. If parameters remain, it then returns to 1 with `dio`=0.
- R4: Only opcode bits [4:0] are decoded. The counts, written as parameters/results, are: 0x06 → 8/7, 0x05 → 8/7, 0x07 → 1/2, 0x13 → 3/1, 0x03 → 2/1 and 0x08 → 0/2. Bits [7:5] are ignored.
- R5: After the last parameter byte, `rqm` stays 0 with no host action for `PROC_CYCLES` + `EXEC_CYCLES` cycles. The execution phase fills the final `EXEC_CYCLES` of these.
- R6: `fifo_en` equals `cfg_fifo_en` during the execution phase and is 0 in every other phase.
- R7: When the result phase begins, `irq` rises together with `rqm`=1 and `dio`=1. Result byte k (k from 0) reads as the opcode byte plus k, modulo 256.
- R8: `irq` falls after the first read of the result phase. After every read except the last, `rqm` is 0 for `PROC_CYCLES` cycles while `dio` stays 1.
- R9: After the last result byte is read, `dio`=0 and `rqm`=1 in the next cycle. A read outside the result phase has no effect, and `rd_data` is 0 outside the result phase.
- R10: An opcode not in the table is followed by no parameter request and no execution phase. After `PROC_CYCLES` cycles the result phase starts with one byte, 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Command or parameter byte |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Current result byte |
| cfg_fifo_en | input | 1 | FIFO enable set by configuration |
| rqm | output | 1 | Ready for a host transfer |
| dio | output | 1 | Direction: 1 = block to host |
| irq | output | 1 | Interrupt at the start of the result phase |
| fifo_en | output | 1 | Gated FIFO enable |

## Verification
Two strobes can meet in one cycle during the result phase: a host read and a host write. The read must be taken and the write ignored. The bench drives both strobes together, once on a middle result byte and once on the last result byte. On the last byte the block returns to the command phase in the very next cycle. The test is then judged by running a complete known command straight after the collision. If the stray write had been taken as an opcode, the parameter gaps, the execution length and the result values of that command would not match the expected ones.

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq #(
  parameter int PROC_CYCLES = 4,
  parameter int EXEC_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       cfg_fifo_en,
  output logic       rqm,
  output logic       dio,
  output logic       irq,
  output logic       fifo_en
);
  localparam int MAXC = (PROC_CYCLES > EXEC_CYCLES) ? PROC_CYCLES : EXEC_CYCLES;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PLOAD = CW'(PROC_CYCLES - 1);
  localparam logic [CW-1:0] XLOAD = CW'(EXEC_CYCLES - 1);

  typedef enum logic [2:0] {S_CMD, S_CBSY, S_EXEC, S_RES, S_RBSY} phase_t;

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic [3:0]    npar, nres, ridx;
  logic [7:0]    op;
  logic          first, bad, irq_q;

  function automatic logic [8:0] lookup(input logic [4:0] c);
    case (c)
      5'h06, 5'h05: lookup = {1'b1, 4'd8, 4'd7};
      5'h07:        lookup = {1'b1, 4'd1, 4'd2};
      5'h13:        lookup = {1'b1, 4'd3, 4'd1};
      5'h03:        lookup = {1'b1, 4'd2, 4'd1};
      5'h08:        lookup = {1'b1, 4'd0, 4'd2};
      default:      lookup = {1'b0, 4'd0, 4'd1};
    endcase
  endfunction

  logic [8:0] dec;
  assign dec = lookup(wr_data[4:0]);

  wire wr_ok = wr_en && (ph == S_CMD);
  wire rd_ok = rd_en && (ph == S_RES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= S_CMD;  cnt <= '0;  npar <= '0;  nres <= '0;  ridx <= '0;
      op <= '0;  first <= 1'b1;  bad <= 1'b0;  irq_q <= 1'b0;
    end else begin
      case (ph)
        S_CMD: if (wr_ok) begin
          cnt <= PLOAD;
          ph  <= S_CBSY;
          if (first) begin
            op    <= wr_data;
            bad   <= !dec[8];
            npar  <= dec[7:4];
            nres  <= dec[3:0];
            first <= 1'b0;
          end else begin
            npar <= npar - 4'd1;
          end
        end
        S_CBSY: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (bad) begin
            ph <= S_RES;  ridx <= '0;  irq_q <= 1'b1;
          end else if (npar != '0) ph <= S_CMD;
          else begin
            ph <= S_EXEC;  cnt <= XLOAD;
          end
        end
        S_EXEC: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            ph <= S_RES;  ridx <= '0;  irq_q <= 1'b1;
          end
        end
        S_RES: if (rd_ok) begin
          irq_q <= 1'b0;
          if (nres == 4'd1) begin
            ph <= S_CMD;  first <= 1'b1;  bad <= 1'b0;
          end else begin
            nres <= nres - 4'd1;
            ridx <= ridx + 4'd1;
            cnt  <= PLOAD;
            ph   <= S_RBSY;
          end
        end
        S_RBSY: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else ph <= S_RES;
        end
        default: ph <= S_CMD;
      endcase
    end
  end

  assign rqm     = (ph == S_CMD) || (ph == S_RES);
  assign dio     = (ph == S_RES) || (ph == S_RBSY);
  assign irq     = irq_q;
  assign fifo_en = cfg_fifo_en && (ph == S_EXEC);
  assign rd_data = (ph != S_RES) ? 8'h00 : (bad ? 8'h80 : op + {4'h0, ridx});

  p_rqm_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rqm && !dio) |=> !rqm);
  p_fifo_exec_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |-> (!rqm && !dio));
  p_irq_at_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (rqm && dio));
  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && rd_en && rqm && dio) |=> !irq);
  p_write_in_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rqm && dio && !rd_en) |=> (rqm && dio));
  p_no_data_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rqm && dio) |-> (rd_data == 8'h00));
endmodule

// File: tb/test_fdc_phase_seq.sv
`timescale 1ns/1ps
module test_fdc_phase_seq;
  localparam int P = 3;
  localparam int X = 5;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, cfg_fifo_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic rqm, dio, irq, fifo_en;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  fdc_phase_seq #(.PROC_CYCLES(P), .EXEC_CYCLES(X)) i_fdc_phase_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .cfg_fifo_en(cfg_fifo_en), .rqm(rqm), .dio(dio),
    .irq(irq), .fifo_en(fifo_en));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    wr_data = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic pulse_rd(input logic also_wr, input logic [7:0] d);
    rd_en = 1; wr_en = also_wr; wr_data = d;
    @(posedge clk); #1 rd_en = 0; wr_en = 0;
  endtask

  task automatic count_low(output int n, output int f);
    n = 0; f = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rqm) break;
      n++;
      if (fifo_en) f++;
    end
  endtask

  task automatic run_cmd(input logic [7:0] op, input int np, input int nr,
                         input logic cfg, input logic collide);
    int n, f;
    cfg_fifo_en = cfg;
    @(negedge clk);
    chk("R2 ready before opcode", {rqm, dio}, 2'b10);
    pulse_wr(op);
    for (int k = 0; k < np; k++) begin
      count_low(n, f);
      chk("R3 gap after byte", n, P);
      chk("R6 fifo off in command", f, 0);
      chk("R3 ready for parameter", {rqm, dio}, 2'b10);
      pulse_wr(8'hA0 + 8'(k));
    end
    count_low(n, f);
    chk("R5 gap to result", n, P + X);
    chk("R6 fifo in exec", f, cfg ? X : 0);
    chk("R7 result entry", {rqm, dio, irq}, 3'b111);
    for (int k = 0; k < nr; k++) begin
      chk("R7 result byte", rd_data, 8'(op + 8'(k)));
      pulse_rd(collide, 8'h06);
      if (k == 0) begin
        #1 chk("R8 irq cleared", irq, 0);
      end
      if (k < nr - 1) begin
        count_low(n, f);
        chk("R8 read gap", n, P);
        chk("R8 back in result", {rqm, dio}, 2'b11);
      end else begin
        @(negedge clk);
        chk("R9 command after last", {rqm, dio, irq}, 3'b100);
        chk("R9 no data outside", rd_data, 0);
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {rqm, dio, irq, fifo_en}, 4'b1000);
  endtask

  task automatic t_invalid;
    int n, f;
    @(negedge clk);
    pulse_wr(8'h1F);
    count_low(n, f);
    chk("R10 gap then result", n, P);
    chk("R10 no exec", f, 0);
    chk("R10 result state", {rqm, dio, irq}, 3'b111);
    chk("R10 status byte", rd_data, 8'h80);
    pulse_rd(0, 0);
    @(negedge clk);
    chk("R10 single byte", {rqm, dio}, 2'b10);
  endtask

  task automatic t_ignored;
    int n, f;
    @(negedge clk);
    rd_en = 1; @(posedge clk); #1 rd_en = 0;
    @(negedge clk);
    chk("R9 read ignored in command", {rqm, dio, irq}, 3'b100);
    pulse_wr(8'h03);
    @(negedge clk);
    wr_data = 8'h55; wr_en = 1; @(posedge clk); #1 wr_en = 0;
    count_low(n, f);
    chk("R2 busy write ignored", n, P - 1);
    pulse_wr(8'h11);
    count_low(n, f);
    chk("R2 still one param left", n, P);
    pulse_wr(8'h12);
    count_low(n, f);
    chk("R2 exec after second param", n, P + X);
    chk("R2 result entry", {rqm, dio}, 2'b11);
    pulse_wr(8'h99);
    @(negedge clk);
    chk("R2 result write ignored", {rqm, dio, 8'(rd_data)}, {2'b11, 8'h03});
    pulse_rd(0, 0);
    @(negedge clk);
    chk("R9 done", {rqm, dio}, 2'b10);
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    run_cmd(8'h06, 8, 7, 1, 0);   // R4
    run_cmd(8'hE7, 1, 2, 1, 0);   // R4 upper bits ignored
    run_cmd(8'h08, 0, 2, 0, 0);   // R4 zero parameters
    run_cmd(8'h13, 3, 1, 0, 0);   // R4
    t_invalid();
    t_ignored();
    run_cmd(8'h07, 1, 2, 1, 1);   // R2 collision of read and write
    run_cmd(8'h05, 8, 7, 0, 0);   // R2 follow-up proves no stray opcode
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule